// File: doc/BRIEF.md
# Branch Condition Evaluator

This block tells the fetch stage whether a conditional branch goes. The branch's 3-bit condition code is tested against the zero, negative and overflow flags. These flags are whatever the most recent flag-writing instruction left behind. Instructions that do not write flags, such as byte loads or skipped conditional adds, leave the old values in place. The evaluator therefore sees the last written values, and the flag register itself lives outside this block.

Eight conditions can be chosen: equal, not-equal, the four signed orderings, overflow, and always. The signed orderings use only the negative and zero flags, so an add that saturated and set the overflow flag still counts as greater-than when its result is positive and non-zero. The decision is registered. It appears on `taken_o` one clock after the branch is presented, and it is held low whenever no branch is presented.

Top module: `brc_eval_top`

## Requirements
- R1: While `rst` is high at a rising edge, `taken_o` is 0 after that edge, whatever the other inputs are.
- R2: Code 3'b000 (not-equal) is taken exactly when Z=0, and code 3'b001 (equal) is taken exactly when Z=1.
- R3: Code 3'b010 (greater-than) is taken exactly when Z=0 and N=0. V has no influence, so Z=0, N=0, V=1 is taken.
- R4: Code 3'b011 (less-than) is taken exactly when N=1, whatever Z and V are.
- R5: Code 3'b100 (greater-or-equal) is taken exactly when N=0, and code 3'b101 (less-or-equal) is taken exactly when Z=1 or N=1.
- R6: Code 3'b110 (overflow) is taken exactly when V=1.
- R7: Code 3'b111 (always) is taken for every combination of flags.
- R8: When `br_valid_i` is 0 at an edge, `taken_o` is 0 after that edge, whatever the code and flags are.
- R9: The decision for the inputs sampled at one rising edge appears on `taken_o` after that edge and is held until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid_i | input | 1 | A branch is being presented this cycle |
| cond_i | input | 3 | Condition code |
| flag_z_i | input | 1 | Zero flag from the last flag-writing instruction |
| flag_n_i | input | 1 | Negative flag from the last flag-writing instruction |
| flag_v_i | input | 1 | Overflow flag from the last flag-writing instruction |
| taken_o | output | 1 | Branch-taken decision, registered |

## Verification
Every decision is due exactly one rising edge after its inputs are sampled. The bench drives the strobe, code and flags on the falling edge. On the next falling edge it compares `taken_o` with a model value computed from the inputs it drove one cycle earlier, and only then applies new inputs. This compare happens on every clock. The main sweep covers all eight codes against all eight flag combinations, both with the strobe high and with it low. Directed cases add the saturated-add pattern for greater-than, and a reset asserted while an always-taken branch is presented.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int COND_W   = 3;
  localparam int NUM_COND = 1 << COND_W;

  typedef enum logic [COND_W-1:0] {
    BC_NE = 3'd0,
    BC_EQ = 3'd1,
    BC_GT = 3'd2,
    BC_LT = 3'd3,
    BC_GE = 3'd4,
    BC_LE = 3'd5,
    BC_OV = 3'd6,
    BC_AL = 3'd7
  } brc_cond_e;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
  } brc_flags_t;
endpackage

// File: rtl/brc_cond_table.sv
// Evaluates every condition in parallel from the current flags.
module brc_cond_table
  import brc_pkg::*;
(
  input  brc_flags_t            flags,
  output logic [NUM_COND-1:0]   hit
);
  for (genvar i = 0; i < NUM_COND; i++) begin : g_cond
    localparam brc_cond_e CODE = brc_cond_e'(COND_W'(i));
    always_comb begin
      case (CODE)
        BC_NE:   hit[i] = ~flags.z;
        BC_EQ:   hit[i] = flags.z;
        BC_GT:   hit[i] = ~flags.z & ~flags.n;
        BC_LT:   hit[i] = flags.n;
        BC_GE:   hit[i] = ~flags.n;
        BC_LE:   hit[i] = flags.z | flags.n;
        BC_OV:   hit[i] = flags.v;
        default: hit[i] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/brc_select.sv
// Picks one condition result by code.
module brc_select #(
  parameter int SEL_W = 3,
  localparam int N    = 1 << SEL_W
) (
  input  logic [N-1:0]     hits,
  input  logic [SEL_W-1:0] sel,
  output logic             pick
);
  always_comb pick = hits[sel];
endmodule

// File: rtl/brc_eval_top.sv
module brc_eval_top
  import brc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              br_valid_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic              flag_z_i,
  input  logic              flag_n_i,
  input  logic              flag_v_i,
  output logic              taken_o
);
  brc_flags_t          flags;
  logic [NUM_COND-1:0] hits;
  logic                sel_hit;

  assign flags = '{z: flag_z_i, n: flag_n_i, v: flag_v_i};

  brc_cond_table u_table (
    .flags (flags),
    .hit   (hits)
  );

  brc_select #(.SEL_W(COND_W)) u_sel (
    .hits (hits),
    .sel  (cond_i),
    .pick (sel_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) taken_o <= 1'b0;
    else     taken_o <= br_valid_i & sel_hit;
  end
endmodule

// File: rtl/brc_eval_checker.sv
module brc_eval_checker (
  input logic       clk,
  input logic       rst,
  input logic       br_valid_i,
  input logic [2:0] cond_i,
  input logic       flag_z_i,
  input logic       flag_n_i,
  input logic       flag_v_i,
  input logic       taken_o
);
  assert_idle_low_R8: assert property (@(posedge clk) disable iff (rst)
    !br_valid_i |=> !taken_o);

  assert_always_taken_R7: assert property (@(posedge clk) disable iff (rst)
    (br_valid_i && cond_i == 3'b111) |=> taken_o);

  assert_ovfl_follows_v_R6: assert property (@(posedge clk) disable iff (rst)
    (br_valid_i && cond_i == 3'b110) |=> (taken_o == $past(flag_v_i)));

  assert_eq_follows_z_R2: assert property (@(posedge clk) disable iff (rst)
    (br_valid_i && cond_i == 3'b001) |=> (taken_o == $past(flag_z_i)));

  assert_gt_ignores_v_R3: assert property (@(posedge clk) disable iff (rst)
    (br_valid_i && cond_i == 3'b010 && !flag_z_i && !flag_n_i) |=> taken_o);

  assert_lt_follows_n_R4: assert property (@(posedge clk) disable iff (rst)
    (br_valid_i && cond_i == 3'b011) |=> (taken_o == $past(flag_n_i)));

  assert_ge_follows_n_R5: assert property (@(posedge clk) disable iff (rst)
    (br_valid_i && cond_i == 3'b100) |=> (taken_o == !$past(flag_n_i)));
endmodule

bind brc_eval_top brc_eval_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .br_valid_i (br_valid_i),
  .cond_i     (cond_i),
  .flag_z_i   (flag_z_i),
  .flag_n_i   (flag_n_i),
  .flag_v_i   (flag_v_i),
  .taken_o    (taken_o)
);

// File: tb/tb_brc_eval_top.sv
`timescale 1ns/1ps
module tb_brc_eval_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       br_valid_i = 1'b0;
  logic [2:0] cond_i = 3'd0;
  logic       flag_z_i = 1'b0, flag_n_i = 1'b0, flag_v_i = 1'b0;
  logic       taken_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit exp_taken = 0;
  string exp_tag = "R1";

  always #5 clk = ~clk;

  brc_eval_top dut (
    .clk(clk), .rst(rst), .br_valid_i(br_valid_i), .cond_i(cond_i),
    .flag_z_i(flag_z_i), .flag_n_i(flag_n_i), .flag_v_i(flag_v_i),
    .taken_o(taken_o)
  );

  function automatic bit model(bit r, bit vld, int c, bit z, bit n, bit v);
    if (r || !vld) return 0;
    case (c)
      0: return !z;
      1: return z;
      2: return !z && !n;
      3: return n;
      4: return !n;
      5: return z || n;
      6: return v;
      default: return 1;
    endcase
  endfunction

  function automatic string tag_of(bit r, bit vld, int c);
    if (r) return "R1";
    if (!vld) return "R8";
    case (c)
      0, 1: return "R2";
      2: return "R3";
      3: return "R4";
      4, 5: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Compare the output for the previous inputs, then drive new ones (R9).
  task automatic step(bit r, bit vld, int c, bit z, bit n, bit v);
    @(negedge clk);
    checks++;
    if (taken_o !== exp_taken) begin
      errors++;
      $display("FAIL %s (R9 timing): taken_o=%b expected=%b", exp_tag, taken_o, exp_taken);
    end
    rst = r; br_valid_i = vld; cond_i = 3'(c);
    flag_z_i = z; flag_n_i = n; flag_v_i = v;
    exp_taken = model(r, vld, c, z, n, v);
    exp_tag = tag_of(r, vld, c);
  endtask

  initial begin
    // R1: reset held with an always-taken branch presented
    step(1, 1, 7, 0, 0, 0);
    step(1, 1, 7, 1, 1, 1);
    step(1, 1, 7, 0, 1, 0);
    // Exhaustive sweep: R2..R8
    for (int vld = 1; vld >= 0; vld--)
      for (int c = 0; c < 8; c++)
        for (int f = 0; f < 8; f++)
          step(0, vld[0], c, f[2], f[1], f[0]);
    // R3: saturated add leaves Z=0 N=0 V=1, greater-than still taken
    step(0, 1, 2, 0, 0, 1);
    // R4: less-than with overflow set but N=0 not taken
    step(0, 1, 3, 0, 0, 1);
    // R6 then R7 back to back, flags alternating
    step(0, 1, 6, 1, 1, 0);
    step(0, 1, 7, 1, 1, 1);
    // R9: decision held across alternating taken/not-taken
    step(0, 1, 1, 1, 0, 0);
    step(0, 1, 1, 0, 0, 0);
    step(0, 1, 1, 1, 0, 0);
    // R1: reset in mid-run while a taken branch is presented
    step(1, 1, 7, 0, 0, 0);
    step(0, 1, 5, 1, 0, 0);
    step(0, 0, 7, 0, 0, 0);
    step(0, 0, 7, 0, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule